// File: doc/BRIEF.md
# Latency-Compensating Periodic Tick Timer

This block is a 16-bit up-counter that produces a periodic tick whose spacing does not drift, even when the agent that services each tick responds after a variable number of machine cycles. The counter advances once per machine cycle, which is marked by a one-clock enable. When the count wraps from all-ones to zero, an overflow flag is set and a one-clock tick pulse is emitted. The counter then keeps counting. When the servicing agent gets round to reloading, the count already equals the number of machine cycles that have passed since the wrap.

A reload request does not load an absolute value. It halts the counter and adds a signed reload constant to the current count, one byte per machine cycle, starting with the low byte. The carry from each byte passes to the next. The counter stays halted for a fixed number of machine cycles (`HALT_CYC`, default 7) and then resumes. For a period of P machine cycles the constant is 2^16 − (P − 7). The service latency is already held in the count and the halt allowance is built into the constant, so the next wrap comes exactly P machine cycles after the previous one.

Control is a three-state machine. `ST_RUN` counts and accepts requests. `ST_ADD` performs one byte lane of the sum per machine cycle. `ST_SETTLE` uses up the remaining halted machine cycles. The transitions are: ST_RUN→ST_ADD on an accepted request; ST_ADD→ST_SETTLE on the machine cycle that writes the top byte lane; ST_SETTLE→ST_RUN on the last halted machine cycle.

Top module: `ltt_tick_timer`

## Requirements
- R1: After reset, count is 0, the overflow flag is 0, the tick output is 0 and the controller is in ST_RUN.
- R2: In ST_RUN with run high, count increments by one on each clock edge where cyc_en is high. Clock edges with cyc_en low leave count unchanged.
- R3: While run is low, count holds in ST_RUN even when cyc_en is high.
- R4: On the edge where count wraps from 0xFFFF to 0x0000, ovf_flag becomes 1 and tick is high for exactly one clock.
- R5: ovf_flag stays 1 until a reload request is accepted. On the accepting edge the flag is cleared, unless a wrap occurs on that same edge.
- R6: A reload request is accepted only when reload_req is high in ST_RUN. The increment due on the accepting edge still takes place. After that, count is halted for exactly HALT_CYC (7) enabled machine cycles.
- R7: After the halted cycles, count equals the count captured at acceptance plus reload_val, modulo 2^16. The sum is formed byte by byte, low byte first, with the low-byte carry added into the high byte. The carry out of the top byte is dropped and does not set ovf_flag. reload_val must be held stable during the halted cycles.
- R8: Counting resumes on the first enabled machine cycle after the last halted one.
- R9: With reload_val = 2^16 − (P − 7), successive ticks are exactly P enabled machine cycles apart for any service latency, including random latencies of 3 to 9 machine cycles.
- R10: reload_req asserted while in ST_ADD or ST_SETTLE is ignored. It neither extends the halt nor changes the sum.
- R11: If a wrap and an accepted request occur on the same edge, ovf_flag stays 1, tick still pulses, and the captured count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | One-clock machine-cycle enable |
| run | input | 1 | Count enable in ST_RUN |
| reload_req | input | 1 | Reload request strobe |
| reload_val | input | 16 | Signed reload constant added to the count |
| ovf_flag | output | 1 | Sticky overflow flag |
| count | output | 16 | Current counter value |
| tick | output | 1 | One-clock pulse on each wrap |

## Verification
The wrap of the counter and the acceptance of a reload request can land on the same clock edge. That happens when the servicing agent issues a request on the very machine cycle in which count goes from 0xFFFF to 0. The bench provokes this by stepping until count reads 0xFFFF and then issuing the request together with the next enable. It then checks four things: that the tick is emitted; that the flag stays set (set wins over clear); that the sum is formed from a captured count of 0; and that the following tick still arrives exactly one period later.

// File: rtl/ltt_pkg.sv
package ltt_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ADD    = 2'd1,
        ST_SETTLE = 2'd2
    } ltt_state_t;

endpackage

// File: rtl/ltt_ctrl.sv
module ltt_ctrl
    import ltt_pkg::*;
#(
    parameter int NBYTES   = 2,
    parameter int HALT_CYC = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_en,
    input  logic                  run,
    input  logic                  reload_req,
    output logic                  inc_en,
    output logic                  add_en,
    output logic                  accept,
    output logic [((NBYTES > 1) ? $clog2(NBYTES) : 1)-1:0] lane_idx
);

    localparam int LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int HC_W   = $clog2(HALT_CYC);

    ltt_state_t      state_q, state_d;
    logic [HC_W-1:0] hc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // halted machine-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             hc_q <= '0;
        else if (accept)                        hc_q <= '0;
        else if (state_q != ST_RUN && cyc_en)   hc_q <= hc_q + HC_W'(1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (reload_req)
                           state_d = ST_ADD;
            ST_ADD:    if (cyc_en && hc_q == HC_W'(NBYTES - 1))
                           state_d = ST_SETTLE;
            ST_SETTLE: if (cyc_en && hc_q == HC_W'(HALT_CYC - 1))
                           state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        inc_en   = 1'b0;
        add_en   = 1'b0;
        accept   = 1'b0;
        lane_idx = hc_q[LANE_W-1:0];
        unique case (state_q)
            ST_RUN: begin
                inc_en = run && cyc_en;
                accept = reload_req;
            end
            ST_ADD:    add_en = cyc_en;
            ST_SETTLE: ;
            default:   ;
        endcase
    end

    // R6
    accept_to_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> state_q == ST_ADD);

    // R6
    add_lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ADD |-> hc_q < HC_W'(NBYTES));

    // R8
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && cyc_en && hc_q == HC_W'(HALT_CYC - 1))
        |=> state_q == ST_RUN);

    // R10
    no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_RUN |-> !accept);

endmodule

// File: rtl/ltt_count.sv
module ltt_count #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic              add_en,
    input  logic              accept,
    input  logic [((CNT_W/BYTE_W > 1) ? $clog2(CNT_W/BYTE_W) : 1)-1:0] lane_idx,
    input  logic [CNT_W-1:0]  reload_val,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);

    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [CNT_W-1:0]              count_q, count_d;
    logic                          carry_q, carry_d;
    logic [NBYTES-1:0][BYTE_W:0]   lane_sum;

    // one adder per byte lane, each fed by the stored carry
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_sum[g] = {1'b0, count_q[g*BYTE_W +: BYTE_W]}
                           + {1'b0, reload_val[g*BYTE_W +: BYTE_W]}
                           + (BYTE_W+1)'(carry_q);
    end

    always_comb begin
        count_d = count_q;
        carry_d = carry_q;
        if (accept) carry_d = 1'b0;
        if (inc_en) begin
            count_d = count_q + CNT_W'(1);
        end else if (add_en) begin
            for (int l = 0; l < NBYTES; l++) begin
                if (lane_idx == LANE_W'(l)) begin
                    count_d[l*BYTE_W +: BYTE_W] = lane_sum[l][BYTE_W-1:0];
                    carry_d                     = lane_sum[l][BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            carry_q <= 1'b0;
        end else begin
            count_q <= count_d;
            carry_q <= carry_d;
        end
    end

    assign count = count_q;
    assign wrap  = inc_en && (&count_q);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !add_en) |=> $stable(count_q));

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count_q == '0);

    // R7
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !carry_q);

endmodule

// File: rtl/ltt_flag.sv
module ltt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic accept,
    output logic flag,
    output logic tick
);

    logic flag_q, tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (wrap)        flag_q <= 1'b1;
            else if (accept) flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign tick = tick_q;

    // R4
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag_q && tick_q));

    // R5
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wrap) |=> !flag_q);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !accept) |=> $stable(flag_q));

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/ltt_tick_timer.sv
module ltt_tick_timer #(
    parameter int CNT_W    = 16,
    parameter int BYTE_W   = 8,
    parameter int HALT_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             run,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] reload_val,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] count,
    output logic             tick
);

    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic              inc_en, add_en, accept, wrap;
    logic [LANE_W-1:0] lane_idx;

    ltt_ctrl #(
        .NBYTES   (NBYTES),
        .HALT_CYC (HALT_CYC)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_en     (cyc_en),
        .run        (run),
        .reload_req (reload_req),
        .inc_en     (inc_en),
        .add_en     (add_en),
        .accept     (accept),
        .lane_idx   (lane_idx)
    );

    ltt_count #(
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W)
    ) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_en     (inc_en),
        .add_en     (add_en),
        .accept     (accept),
        .lane_idx   (lane_idx),
        .reload_val (reload_val),
        .count      (count),
        .wrap       (wrap)
    );

    ltt_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .accept (accept),
        .flag   (ovf_flag),
        .tick   (tick)
    );

    // R3
    run_low_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !add_en) |=> $stable(count));

endmodule

// File: tb/ltt_tick_timer_tb_top.sv
module ltt_tick_timer_tb_top;

    localparam int P    = 300;
    localparam int HALT = 7;
    localparam logic [15:0] KVAL = 16'(65536 - (P - HALT));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic        run = 1'b0;
    logic        reload_req = 1'b0;
    logic [15:0] reload_val = '0;
    logic        ovf_flag;
    logic [15:0] count;
    logic        tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        s_tick, s_flag;
    logic [15:0] s_cnt;

    always #5 clk = ~clk;

    ltt_tick_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_en     (cyc_en),
        .run        (run),
        .reload_req (reload_req),
        .reload_val (reload_val),
        .ovf_flag   (ovf_flag),
        .count      (count),
        .tick       (tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one machine cycle: enable for one clock, sample before dropping it
    task automatic step(input logic req);
        @(negedge clk);
        cyc_en     = 1'b1;
        reload_req = req;
        @(negedge clk);
        s_tick     = tick;
        s_flag     = ovf_flag;
        s_cnt      = count;
        cyc_en     = 1'b0;
        reload_req = 1'b0;
    endtask

    task automatic halt_steps(output logic [15:0] at6);
        at6 = '0;
        for (int i = 1; i <= HALT; i++) begin
            step(1'b0);
            if (i == HALT - 1) at6 = s_cnt;
        end
    endtask

    task automatic wait_tick(inout int n);
        for (int i = 0; i < 3000; i++) begin
            step(1'b0);
            n++;
            if (s_tick) break;
        end
    endtask

    task automatic t_reset();
        chk("R1 count", 32'(count), 32'h0);
        chk("R1 flag", 32'(ovf_flag), 32'h0);
        chk("R1 tick", 32'(tick), 32'h0);
    endtask

    task automatic t_count();
        run = 1'b1;
        for (int i = 0; i < 5; i++) step(1'b0);
        chk("R2 five cycles", 32'(s_cnt), 32'h5);
        repeat (4) @(negedge clk);
        chk("R2 idle clocks", 32'(count), 32'h5);
    endtask

    task automatic t_run();
        run = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0);
        chk("R3 frozen", 32'(s_cnt), 32'h5);
        run = 1'b1;
        step(1'b0);
        chk("R3 resumed", 32'(s_cnt), 32'h6);
    endtask

    task automatic t_carry();
        logic [15:0] c6;
        reload_val = 16'h00FF;
        step(1'b1);
        chk("R6 accept edge increments", 32'(s_cnt), 32'h7);
        halt_steps(c6);
        chk("R6 halted at step 6", 32'(c6), 32'h0106);
        chk("R7 low carry", 32'(s_cnt), 32'h0106);
        step(1'b0);
        chk("R8 resume", 32'(s_cnt), 32'h0107);
        reload_val = 16'hFF00;
        step(1'b1);
        chk("R6 accept edge", 32'(s_cnt), 32'h0108);
        halt_steps(c6);
        chk("R7 top carry dropped", 32'(s_cnt), 32'h0008);
        chk("R7 no flag from sum", 32'(s_flag), 32'h0);
        step(1'b0);
        chk("R8 resume two", 32'(s_cnt), 32'h0009);
    endtask

    task automatic t_ignore();
        reload_val = 16'h0010;
        step(1'b1);
        chk("R10 accept", 32'(s_cnt), 32'h000A);
        for (int i = 1; i <= HALT; i++) step(i == 2 || i == 5 || i == 7);
        chk("R10 sum unchanged", 32'(s_cnt), 32'h001A);
        step(1'b0);
        chk("R10 no extra halt", 32'(s_cnt), 32'h001B);
    endtask

    task automatic t_periods();
        int n;
        int lat;
        reload_val = KVAL;
        step(1'b1);
        n = 0;
        wait_tick(n);
        chk("R4 first tick", 32'(s_tick), 32'h1);
        chk("R4 wrapped to zero", 32'(s_cnt), 32'h0);
        chk("R4 flag set", 32'(s_flag), 32'h1);
        for (int k = 0; k < 6; k++) begin
            lat = int'($urandom_range(9, 3));
            n = 0;
            for (int i = 1; i <= lat; i++) begin
                step(i == lat);
                n++;
                if (i == lat - 1) chk("R5 flag held", 32'(s_flag), 32'h1);
            end
            chk("R5 flag cleared", 32'(s_flag), 32'h0);
            wait_tick(n);
            chk("R9 tick spacing", 32'(n), 32'(P));
            chk("R4 tick pulse", 32'(s_tick), 32'h1);
        end
    endtask

    task automatic t_collision();
        int n;
        logic [15:0] c6;
        for (int i = 1; i <= 5; i++) step(i == 5);
        for (int i = 0; i < 3000; i++) begin
            step(1'b0);
            if (s_cnt == 16'hFFFF) break;
        end
        chk("R11 reached all ones", 32'(s_cnt), 32'hFFFF);
        step(1'b1);
        chk("R11 tick", 32'(s_tick), 32'h1);
        chk("R11 flag kept", 32'(s_flag), 32'h1);
        n = 0;
        halt_steps(c6);
        n += HALT;
        chk("R11 sum from zero", 32'(s_cnt), 32'(KVAL));
        chk("R11 flag still set", 32'(s_flag), 32'h1);
        wait_tick(n);
        chk("R11 spacing", 32'(n), 32'(P));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_run();
        t_carry();
        t_ignore();
        t_periods();
        t_collision();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule